// File: doc/BRIEF.md
# System Management Host Register Block (device side)

This block sits on the management controller's side of a byte-wide, three-register host interface. The host reaches it over a two-bit address with a write strobe and a combinational read path. Offset 0 is the data register, offset 1 the control (write) / status (read) register and offset 2 the flags register. On the other side, a local controller sees a plain request/response port. It receives a one-cycle command pulse with the control byte and the data byte the host posted. It answers with a done strobe that carries a result byte and the new receive/transmit readiness.

The busy flag (flags bit 0) works as an ownership token. The host raises it by writing the flags register with bit 0 set. Only the device side lowers it, and it does so in the same clock edge that posts a status equal to the accepted control code with bit 7 set. A control code outside the configured legal window is never passed to the local controller. The block answers it on its own with the idle status and the illegal-control error code. The message-available flag is driven by local set/clear strobes and does not depend on the busy token.

Top module: `sysmgmt_host_regs`

## Requirements
- R1: After a synchronous active-low reset, status (offset 1) reads 0xC0, data (offset 0) reads 0x00, flags (offset 2) read 0x00, and `cmd_valid` is low.
- R2: While busy is clear, host writes to offset 1 and offset 0 are held as the pending control and data bytes. A host write of the flags register with bit 0 set then gives exactly one `cmd_valid` pulse in the following cycle, with `cmd_ctrl`/`cmd_data` carrying those bytes, and flags bit 0 reads 1.
- R3: While busy is set, host writes to offsets 0, 1 and 2 are ignored. The pending bytes stay unchanged and no further command pulse appears.
- R4: Busy stays set until the local side gives `loc_done`. A `loc_done` while busy is clear changes no host-visible register.
- R5: On `loc_done` while a legal command is owned, the next cycle shows status = control code OR 0x80 (for example 0x42 gives 0xC2), data = `loc_data`, flags bit 7 = `loc_rx_rdy`, flags bit 6 = `loc_tx_rdy` and busy clear.
- R6: A launched control code below CODE_LO (0x40) or above CODE_HI (0x46) raises no `cmd_valid`. Busy reads 1 for one cycle after launch. After the next edge, status reads 0xC0, data reads 0x02 (illegal control), busy is clear and flags bits 7 and 6 are unchanged.
- R7: Flags bit 2 (message available) is set by `loc_msg_set` and cleared by `loc_msg_clr`, with set winning when both are high. It changes regardless of busy.
- R8: Flags bits 5, 4, 3 and 1 always read 0, so the flags register can never read 0xFF. Offset 3 reads 0x00.
- R9: A host flags write with bit 0 clear starts nothing, and the host cannot write any flag bit directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Host register select (0 data, 1 control/status, 2 flags) |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected register |
| cmd_valid | output | 1 | One-cycle pulse: a legal command has been handed to the local side |
| cmd_ctrl | output | 8 | Pending control byte |
| cmd_data | output | 8 | Pending data byte |
| loc_done | input | 1 | Local side finished the owned step |
| loc_data | input | 8 | Response byte or error code posted with `loc_done` |
| loc_rx_rdy | input | 1 | Response byte available, captured with `loc_done` |
| loc_tx_rdy | input | 1 | Another write byte acceptable, captured with `loc_done` |
| loc_msg_set | input | 1 | Set the message-available flag |
| loc_msg_clr | input | 1 | Clear the message-available flag |

## Verification
The bench builds the block with its default legal window of 0x40 to 0x46. Both edge codes, 0x40 and 0x46, and both neighbours just outside the window, 0x3F and 0x47, are therefore driven directly from the host side. This shows the local side seeing only in-window codes and the block closing out-of-window ones itself. Ownership is tested by hammering all three offsets while a command is pending. Stray done strobes and competing message strobes are driven with busy both set and clear.

// File: rtl/sysmgmt_pkg.sv
// Shared constants for the system management host register block.
// Assumes a byte-wide host bus and a two-bit register address.
package sysmgmt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    typedef logic [BYTE_W-1:0] byte_t;

    // Register offsets; the host software decodes these.
    localparam logic [ADDR_W-1:0] OFS_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_CS    = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_FLAGS = 2'd2;

    // Flag bit positions seen by the host.
    localparam int FB_RXRDY = 7;
    localparam int FB_TXRDY = 6;
    localparam int FB_MSG   = 2;
    localparam int FB_BUSY  = 0;

    // Status marker and response codes.
    localparam byte_t ST_MARK        = 8'h80;
    localparam byte_t ST_IDLE        = 8'hC0;
    localparam byte_t ERR_ILLEGAL_CC = 8'h02;
endpackage

// File: rtl/sysmgmt_cmd_latch.sv
// Holds the pending control/data bytes and the busy ownership token.
// Launches a command on a host flags write with the busy bit set. A legal
// code is pulsed to the local side; an illegal one is closed out internally
// on the next edge. Assumes host writes last one cycle.
module sysmgmt_cmd_latch
    import sysmgmt_pkg::*;
#(
    parameter byte_t CODE_LO = 8'h40,
    parameter byte_t CODE_HI = 8'h46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  byte_t             host_wdata,
    input  logic              loc_done,
    output logic              busy,
    output logic              cmd_valid,
    output byte_t             cmd_ctrl,
    output byte_t             cmd_data,
    output logic              fin_ok,
    output logic              fin_bad
);
    logic launch;
    logic legal;
    logic bad_q;

    // Launch condition: host offers the token while the device does not own it.
    always_comb begin
        launch = host_wr && (host_addr == OFS_FLAGS) && host_wdata[FB_BUSY] && !busy;
        legal  = (cmd_ctrl >= CODE_LO) && (cmd_ctrl <= CODE_HI);
        fin_ok  = busy && !bad_q && loc_done;
        fin_bad = bad_q;
    end

    // Pending bytes, token and command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ctrl  <= '0;
            cmd_data  <= '0;
            busy      <= 1'b0;
            cmd_valid <= 1'b0;
            bad_q     <= 1'b0;
        end else begin
            cmd_valid <= launch && legal;
            bad_q     <= launch && !legal;
            if (!busy && host_wr && (host_addr == OFS_CS))
                cmd_ctrl <= host_wdata;
            if (!busy && host_wr && (host_addr == OFS_DATA))
                cmd_data <= host_wdata;
            if (launch)
                busy <= 1'b1;
            else if (fin_ok || fin_bad)
                busy <= 1'b0;
        end
    end

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R6
    legal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_ctrl >= CODE_LO && cmd_ctrl <= CODE_HI));
    // R3
    own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> ($stable(cmd_ctrl) && $stable(cmd_data)));
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(loc_done) || $past(bad_q)));
endmodule

// File: rtl/sysmgmt_resp_regs.sv
// Device-owned host-visible state: status, response data, readiness flags
// and the message-available flag. Updated only by the completion strobes
// from the command latch and by the local message strobes.
module sysmgmt_resp_regs
    import sysmgmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fin_ok,
    input  logic  fin_bad,
    input  byte_t cmd_ctrl,
    input  byte_t loc_data,
    input  logic  loc_rx_rdy,
    input  logic  loc_tx_rdy,
    input  logic  loc_msg_set,
    input  logic  loc_msg_clr,
    output byte_t status,
    output byte_t dev_data,
    output logic  rx_rdy,
    output logic  tx_rdy,
    output logic  msg_avail
);
    // Status echo, result byte and readiness capture on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status   <= ST_IDLE;
            dev_data <= '0;
            rx_rdy   <= 1'b0;
            tx_rdy   <= 1'b0;
        end else if (fin_bad) begin
            status   <= ST_IDLE;
            dev_data <= ERR_ILLEGAL_CC;
        end else if (fin_ok) begin
            status   <= cmd_ctrl | ST_MARK;
            dev_data <= loc_data;
            rx_rdy   <= loc_rx_rdy;
            tx_rdy   <= loc_tx_rdy;
        end
    end

    // Message-available flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_avail <= 1'b0;
        else if (loc_msg_set)
            msg_avail <= 1'b1;
        else if (loc_msg_clr)
            msg_avail <= 1'b0;
    end

    // R5
    echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> (status == ($past(cmd_ctrl) | ST_MARK)));
    // R6
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_bad |=> (status == ST_IDLE && dev_data == ERR_ILLEGAL_CC && $stable(rx_rdy)));
    // R7
    msg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_msg_set |=> msg_avail);
endmodule

// File: rtl/sysmgmt_read_mux.sv
// Combinational host read path. Assembles the flags byte from the busy token
// and device flags; unused flag bits and the fourth offset read zero.
module sysmgmt_read_mux
    import sysmgmt_pkg::*;
(
    input  logic [ADDR_W-1:0] host_addr,
    input  byte_t             dev_data,
    input  byte_t             status,
    input  logic              busy,
    input  logic              rx_rdy,
    input  logic              tx_rdy,
    input  logic              msg_avail,
    output byte_t             host_rdata
);
    byte_t flags;

    // Flags byte assembly.
    always_comb begin
        flags           = '0;
        flags[FB_RXRDY] = rx_rdy;
        flags[FB_TXRDY] = tx_rdy;
        flags[FB_MSG]   = msg_avail;
        flags[FB_BUSY]  = busy;
    end

    // Register select.
    always_comb begin
        case (host_addr)
            OFS_DATA:  host_rdata = dev_data;
            OFS_CS:    host_rdata = status;
            OFS_FLAGS: host_rdata = flags;
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysmgmt_host_regs.sv
// Top: device-side host register block. Wires the command latch (token
// owner), the response registers and the host read path. Assumes one host
// access per cycle and a local side that answers each command pulse once.
module sysmgmt_host_regs
    import sysmgmt_pkg::*;
#(
    parameter byte_t CODE_LO = 8'h40,
    parameter byte_t CODE_HI = 8'h46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       cmd_valid,
    output logic [7:0] cmd_ctrl,
    output logic [7:0] cmd_data,
    input  logic       loc_done,
    input  logic [7:0] loc_data,
    input  logic       loc_rx_rdy,
    input  logic       loc_tx_rdy,
    input  logic       loc_msg_set,
    input  logic       loc_msg_clr
);
    logic  busy, fin_ok, fin_bad, rx_rdy, tx_rdy, msg_avail;
    byte_t status, dev_data;

    sysmgmt_cmd_latch #(.CODE_LO(CODE_LO), .CODE_HI(CODE_HI)) u_latch (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .loc_done(loc_done), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl), .cmd_data(cmd_data),
        .fin_ok(fin_ok), .fin_bad(fin_bad)
    );

    sysmgmt_resp_regs u_resp (
        .clk(clk), .rst_n(rst_n), .fin_ok(fin_ok), .fin_bad(fin_bad),
        .cmd_ctrl(cmd_ctrl), .loc_data(loc_data), .loc_rx_rdy(loc_rx_rdy),
        .loc_tx_rdy(loc_tx_rdy), .loc_msg_set(loc_msg_set), .loc_msg_clr(loc_msg_clr),
        .status(status), .dev_data(dev_data), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy),
        .msg_avail(msg_avail)
    );

    sysmgmt_read_mux u_rmux (
        .host_addr(host_addr), .dev_data(dev_data), .status(status), .busy(busy),
        .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .msg_avail(msg_avail),
        .host_rdata(host_rdata)
    );

    // R4
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !fin_bad && loc_done) |=> ($stable(status) && $stable(dev_data)));
endmodule

// File: tb/sysmgmt_host_regs_tb_top.sv
`timescale 1ns/1ps
module sysmgmt_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cmd_valid;
    logic [7:0] cmd_ctrl, cmd_data;
    logic       loc_done = 1'b0;
    logic [7:0] loc_data = '0;
    logic       loc_rx_rdy = 1'b0, loc_tx_rdy = 1'b0;
    logic       loc_msg_set = 1'b0, loc_msg_clr = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct { logic [7:0] ctrl; logic [7:0] data; } cmd_t;
    cmd_t exp_q[$];

    always #4 clk = ~clk;

    sysmgmt_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
        .cmd_ctrl(cmd_ctrl), .cmd_data(cmd_data), .loc_done(loc_done),
        .loc_data(loc_data), .loc_rx_rdy(loc_rx_rdy), .loc_tx_rdy(loc_tx_rdy),
        .loc_msg_set(loc_msg_set), .loc_msg_clr(loc_msg_clr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        host_addr = a;
        #1;
        chk(req, host_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: post bytes, push the expected command when legal, then launch.
    task automatic launch(input logic [7:0] c, input logic [7:0] d, input bit legal);
        cmd_t e;
        wr(2'd1, c);
        wr(2'd0, d);
        if (legal) begin
            e.ctrl = c; e.data = d;
            exp_q.push_back(e);
        end
        wr(2'd2, 8'h01);
    endtask

    task automatic finish_step(input logic [7:0] d, input logic rx, input logic tx);
        @(negedge clk);
        loc_done = 1'b1; loc_data = d; loc_rx_rdy = rx; loc_tx_rdy = tx;
        @(negedge clk);
        loc_done = 1'b0;
    endtask

    // Monitor: every command pulse must match the next expected item (R2, R3, R6).
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R6/R3 unexpected cmd pulse actual=%02h expected=none", cmd_ctrl);
            end else begin
                cmd_t e;
                e = exp_q.pop_front();
                chk("R2 cmd_ctrl", cmd_ctrl, e.ctrl);
                chk("R2 cmd_data", cmd_data, e.data);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 8'h00, "R1 data");
        rd(2'd1, 8'hC0, "R1 status");
        rd(2'd2, 8'h00, "R1 flags");
        chk("R1 cmd_valid", {7'b0, cmd_valid}, 8'h00);

        // R2 / R5 lowest legal code
        launch(8'h40, 8'h5A, 1'b1);
        rd(2'd2, 8'h01, "R2 busy set");
        chk("R2 cmd_ctrl held", cmd_ctrl, 8'h40);
        finish_step(8'h00, 1'b1, 1'b0);
        rd(2'd1, 8'hC0, "R5 status echo 40");
        rd(2'd0, 8'h00, "R5 data");
        rd(2'd2, 8'h80, "R5 flags rx");

        // R3 / R4 ownership while busy
        launch(8'h42, 8'hAA, 1'b1);
        rd(2'd2, 8'h81, "R3 busy");
        wr(2'd1, 8'h45);
        wr(2'd0, 8'h11);
        wr(2'd2, 8'h01);
        chk("R3 ctrl unchanged", cmd_ctrl, 8'h42);
        chk("R3 data unchanged", cmd_data, 8'hAA);
        repeat (3) @(negedge clk);
        rd(2'd2, 8'h81, "R4 busy held");
        finish_step(8'h00, 1'b0, 1'b1);
        rd(2'd1, 8'hC2, "R5 status echo 42");
        rd(2'd2, 8'h40, "R5 flags tx");

        // R4 stray done while idle
        finish_step(8'h33, 1'b1, 1'b1);
        rd(2'd1, 8'hC2, "R4 status kept");
        rd(2'd0, 8'h00, "R4 data kept");
        rd(2'd2, 8'h40, "R4 flags kept");

        // R5 highest legal code, error result passed through
        launch(8'h46, 8'h01, 1'b1);
        finish_step(8'h05, 1'b1, 1'b1);
        rd(2'd1, 8'hC6, "R5 status echo 46");
        rd(2'd0, 8'h05, "R5 data code");
        rd(2'd2, 8'hC0, "R5 flags both");

        // R6 just above and just below the window
        launch(8'h47, 8'h00, 1'b0);
        rd(2'd2, 8'hC1, "R6 busy one cycle");
        @(negedge clk);
        rd(2'd1, 8'hC0, "R6 status idle");
        rd(2'd0, 8'h02, "R6 illegal code");
        rd(2'd2, 8'hC0, "R6 flags kept");
        launch(8'h3F, 8'h00, 1'b0);
        @(negedge clk);
        rd(2'd0, 8'h02, "R6 low reject");
        rd(2'd2, 8'hC0, "R6 low busy clear");

        // R7 message flag
        @(negedge clk); loc_msg_set = 1'b1;
        @(negedge clk); loc_msg_set = 1'b0;
        rd(2'd2, 8'hC4, "R7 set");
        launch(8'h41, 8'h07, 1'b1);
        @(negedge clk); loc_msg_clr = 1'b1;
        @(negedge clk); loc_msg_clr = 1'b0;
        rd(2'd2, 8'hC1, "R7 clear while busy");
        @(negedge clk); loc_msg_set = 1'b1; loc_msg_clr = 1'b1;
        @(negedge clk); loc_msg_set = 1'b0; loc_msg_clr = 1'b0;
        rd(2'd2, 8'hC5, "R7 set wins");
        finish_step(8'h00, 1'b0, 1'b0);
        rd(2'd2, 8'h04, "R7 after done");

        // R9 flags write without busy bit
        wr(2'd2, 8'hFE);
        rd(2'd2, 8'h04, "R9 no launch");

        // R8 zero bits, fourth offset
        launch(8'h43, 8'h00, 1'b1);
        finish_step(8'h00, 1'b1, 1'b1);
        rd(2'd2, 8'hC4, "R8 flags max");
        rd(2'd3, 8'h00, "R8 offset 3");

        repeat (2) @(negedge clk);
        chk("R2 queue drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule